// File: doc/BRIEF.md
# Hoisted Load Address Guard Table

This block keeps track of loads that a compiler moved above earlier stores. When such an advanced load executes, it records its address and its destination register tag in a small fully associative table. Every later store compares its address against all live entries at once, and each entry whose 8-byte word matches is invalidated. A check operation later looks the destination tag up. If a live entry holds that tag, the check passes and the entry is released. If the entry was invalidated, evicted or never created, the check reports that recovery code must run.

The table holds eight entries. Each entry has a valid flag, a 32-bit address and a 7-bit tag. Stores search the table by address, while checks and inserts search it by tag. An insert to a tag that is already present reuses that entry. Otherwise the insert takes the lowest free entry, or it evicts a victim chosen by a round-robin pointer when no entry is free. A flush input empties the table in one cycle. The check result appears one clock after the check request.

Top module: `hoist_guard`

## Requirements
- R1: Synchronous reset (`rst` high) leaves every entry invalid and drives `chkDone` and `chkFixup` low. A check issued after reset reports `chkFixup`=1.
- R2: A check presented with `chkValid` high in cycle N raises `chkDone` for exactly cycle N+1. `chkFixup`=0 there means the tag had a live entry.
- R3: A check whose tag has no live entry reports `chkFixup`=1.
- R4: A store invalidates an entry when store address bits [31:3] equal the entry's address bits [31:3]. Bits [2:0] take no part in the comparison.
- R5: A store whose address differs from an entry's in any of bits [31:3] leaves that entry live.
- R6: One store invalidates every entry whose word matches, in the same cycle.
- R7: A passing check releases its entry, so a second check of the same tag reports `chkFixup`=1.
- R8: An insert whose tag matches a live entry replaces that entry's address. Stores to the old address no longer affect the entry, and stores to the new address do.
- R9: An insert with a new tag takes the lowest-numbered invalid entry. When all entries are valid, it evicts the entry at a round-robin pointer. The pointer starts at 0 after reset, advances by one (wrapping) on each eviction, and is not moved by flush.
- R10: When an insert and a store to the same word occur in one cycle, the new entry stays live and older entries for that word are invalidated.
- R11: `flushReq` invalidates all entries in one cycle. An insert in the same cycle is dropped.
- R12: A check sees the table as it stood at the start of its cycle. A store, insert or flush in that same cycle does not change the reported result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flushReq | input | 1 | Invalidate all entries |
| insValid | input | 1 | Advanced-load insert request |
| insAddr | input | 32 | Address of the advanced load |
| insTag | input | 7 | Destination register tag of the advanced load |
| stValid | input | 1 | Store request |
| stAddr | input | 32 | Store address |
| chkValid | input | 1 | Check request |
| chkTag | input | 7 | Tag to check |
| chkDone | output | 1 | Check result valid (one cycle after request) |
| chkFixup | output | 1 | 1 = recovery needed, 0 = pass |

## Verification
The assertions assume that the strobes `insValid`, `stValid`, `chkValid` and `flushReq` carry known values once reset is released. They also assume that the address and tag payloads are steady around the clock edge in any cycle where their strobe is high. The stimulus drives all inputs at the falling edge. Each strobe is held high for one cycle only and is cleared on the following falling edge. Same-cycle combinations are produced on purpose, by raising several strobes before a single step: store with insert, store with check, flush with insert.

// File: rtl/hoist_guard_pkg.sv
package hoist_guard_pkg;

  localparam int unsigned ENTRY_CNT = 8;
  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned TAG_W     = 7;
  localparam int unsigned WORD_LSB  = 3;
  localparam int unsigned IDX_W     = (ENTRY_CNT > 1) ? $clog2(ENTRY_CNT) : 1;

  // Address bits that take part in store matching.
  localparam logic [ADDR_W-1:0] WORD_MASK = {ADDR_W{1'b1}} << WORD_LSB;

  // Strobes from control to datapath.
  typedef struct packed {
    logic                 clearAll;
    logic                 writeEn;
    logic [IDX_W-1:0]     writeIdx;
    logic [ENTRY_CNT-1:0] dropMask;
  } strobes_t;

endpackage

// File: rtl/hoist_guard_dp.sv
module hoist_guard_dp
  import hoist_guard_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  strobes_t             strobes,
  input  logic [ADDR_W-1:0]    insAddr,
  input  logic [TAG_W-1:0]     insTag,
  input  logic                 stValid,
  input  logic [ADDR_W-1:0]    stAddr,
  input  logic [TAG_W-1:0]     chkTag,
  output logic [ENTRY_CNT-1:0] validVec,
  output logic [ENTRY_CNT-1:0] stHitVec,
  output logic [ENTRY_CNT-1:0] insHitVec,
  output logic [ENTRY_CNT-1:0] chkHitVec
);

  for (genvar g = 0; g < ENTRY_CNT; g++) begin : gEntry
    logic              entryValid;
    logic [ADDR_W-1:0] entryAddr;
    logic [TAG_W-1:0]  entryTag;
    logic              isTarget;

    assign isTarget = strobes.writeEn && (strobes.writeIdx == IDX_W'(g));

    // Priority: flush, then insert (youngest), then store/check drop.
    always_ff @(posedge clk) begin
      if (rst) begin
        entryValid <= 1'b0;
      end else if (strobes.clearAll) begin
        entryValid <= 1'b0;
      end else if (isTarget) begin
        entryValid <= 1'b1;
      end else if (strobes.dropMask[g]) begin
        entryValid <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (isTarget && !strobes.clearAll) begin
        entryAddr <= insAddr;
        entryTag  <= insTag;
      end
    end

    // One address comparator and two tag comparators per entry.
    assign validVec[g]  = entryValid;
    assign stHitVec[g]  = entryValid && stValid &&
                          (((entryAddr ^ stAddr) & WORD_MASK) == '0);
    assign insHitVec[g] = entryValid && (entryTag == insTag);
    assign chkHitVec[g] = entryValid && (entryTag == chkTag);

    AST_STORE_KILLS: assert property (@(posedge clk) disable iff (rst)
      (stHitVec[g] && !isTarget) |=> !entryValid); // R4
  end

  AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chkHitVec) && $onehot0(insHitVec)); // R8

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    strobes.clearAll |=> (validVec == '0)); // R11

  AST_INSERT_LANDS: assert property (@(posedge clk) disable iff (rst)
    (strobes.writeEn && !strobes.clearAll) |=> validVec[$past(strobes.writeIdx)]); // R10

endmodule

// File: rtl/hoist_guard_ctrl.sv
module hoist_guard_ctrl
  import hoist_guard_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 flushReq,
  input  logic                 insValid,
  input  logic                 chkValid,
  input  logic [ENTRY_CNT-1:0] validVec,
  input  logic [ENTRY_CNT-1:0] stHitVec,
  input  logic [ENTRY_CNT-1:0] insHitVec,
  input  logic [ENTRY_CNT-1:0] chkHitVec,
  output strobes_t             strobes,
  output logic                 chkDone,
  output logic                 chkFixup
);

  logic [IDX_W-1:0] rrPtr;
  logic [IDX_W-1:0] freeIdx;
  logic [IDX_W-1:0] hitIdx;
  logic             anyFree;
  logic             insHit;
  logic             chkHit;
  logic             evict;

  // Lowest-numbered invalid entry.
  always_comb begin
    freeIdx = '0;
    anyFree = 1'b0;
    for (int i = ENTRY_CNT - 1; i >= 0; i--) begin
      if (!validVec[i]) begin
        freeIdx = IDX_W'(i);
        anyFree = 1'b1;
      end
    end
  end

  // Tags are unique among live entries, so an OR-encode is enough.
  always_comb begin
    hitIdx = '0;
    for (int i = 0; i < ENTRY_CNT; i++) begin
      if (insHitVec[i]) hitIdx = hitIdx | IDX_W'(i);
    end
  end

  assign insHit = |insHitVec;
  assign chkHit = |chkHitVec;
  assign evict  = insValid && !flushReq && !insHit && !anyFree;

  always_comb begin
    strobes.clearAll = flushReq;
    strobes.writeEn  = insValid && !flushReq;
    strobes.writeIdx = insHit ? hitIdx : (anyFree ? freeIdx : rrPtr);
    strobes.dropMask = stHitVec | (chkValid ? chkHitVec : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rrPtr <= '0;
    end else if (evict) begin
      rrPtr <= (rrPtr == IDX_W'(ENTRY_CNT - 1)) ? '0 : rrPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chkDone  <= 1'b0;
      chkFixup <= 1'b0;
    end else begin
      chkDone  <= chkValid;
      chkFixup <= chkValid && !chkHit;
    end
  end

  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    chkValid |=> chkDone); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    !chkValid |=> !chkDone); // R2

  AST_FIXUP_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    chkFixup |-> chkDone); // R3

  AST_RR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    evict |=> (rrPtr != $past(rrPtr))); // R9

  AST_FREE_FIRST: assert property (@(posedge clk) disable iff (rst)
    (strobes.writeEn && !insHit && anyFree) |-> !validVec[strobes.writeIdx]); // R9

endmodule

// File: rtl/hoist_guard.sv
module hoist_guard
  import hoist_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              flushReq,
  input  logic              insValid,
  input  logic [ADDR_W-1:0] insAddr,
  input  logic [TAG_W-1:0]  insTag,
  input  logic              stValid,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic              chkValid,
  input  logic [TAG_W-1:0]  chkTag,
  output logic              chkDone,
  output logic              chkFixup
);

  strobes_t             strobes;
  logic [ENTRY_CNT-1:0] validVec;
  logic [ENTRY_CNT-1:0] stHitVec;
  logic [ENTRY_CNT-1:0] insHitVec;
  logic [ENTRY_CNT-1:0] chkHitVec;

  hoist_guard_ctrl uCtrl (
    .clk       (clk),
    .rst       (rst),
    .flushReq  (flushReq),
    .insValid  (insValid),
    .chkValid  (chkValid),
    .validVec  (validVec),
    .stHitVec  (stHitVec),
    .insHitVec (insHitVec),
    .chkHitVec (chkHitVec),
    .strobes   (strobes),
    .chkDone   (chkDone),
    .chkFixup  (chkFixup)
  );

  hoist_guard_dp uDp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .insAddr   (insAddr),
    .insTag    (insTag),
    .stValid   (stValid),
    .stAddr    (stAddr),
    .chkTag    (chkTag),
    .validVec  (validVec),
    .stHitVec  (stHitVec),
    .insHitVec (insHitVec),
    .chkHitVec (chkHitVec)
  );

endmodule

// File: tb/hoist_guard_test.sv
module hoist_guard_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flushReq = 1'b0;
  logic        insValid = 1'b0;
  logic [31:0] insAddr = '0;
  logic [6:0]  insTag = '0;
  logic        stValid = 1'b0;
  logic [31:0] stAddr = '0;
  logic        chkValid = 1'b0;
  logic [6:0]  chkTag = '0;
  logic        chkDone;
  logic        chkFixup;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic  expQ[$];
  string nameQ[$];

  always #10 clk = ~clk; // 50 MHz

  hoist_guard uut (
    .clk(clk), .rst(rst), .flushReq(flushReq),
    .insValid(insValid), .insAddr(insAddr), .insTag(insTag),
    .stValid(stValid), .stAddr(stAddr),
    .chkValid(chkValid), .chkTag(chkTag),
    .chkDone(chkDone), .chkFixup(chkFixup)
  );

  // Monitor: pops one expectation per result pulse.
  always @(negedge clk) begin
    if (!rst && chkDone) begin
      checks++;
      if (expQ.size() == 0) begin
        failures++;
        $display("FAIL R2 unexpected chkDone: actual=1 expected=0");
      end else begin
        automatic logic  e = expQ.pop_front();
        automatic string n = nameQ.pop_front();
        if (chkFixup !== e) begin
          failures++;
          $display("FAIL %s: chkFixup actual=%0b expected=%0b", n, chkFixup, e);
        end
      end
    end
  end

  task automatic setIns(input logic [6:0] t, input logic [31:0] a);
    insValid = 1'b1; insTag = t; insAddr = a;
  endtask

  task automatic setSt(input logic [31:0] a);
    stValid = 1'b1; stAddr = a;
  endtask

  task automatic setChk(input logic [6:0] t, input logic e, input string n);
    chkValid = 1'b1; chkTag = t;
    expQ.push_back(e); nameQ.push_back(n);
  endtask

  task automatic step();
    @(negedge clk);
    insValid = 1'b0; stValid = 1'b0; chkValid = 1'b0; flushReq = 1'b0;
  endtask

  task automatic ins(input logic [6:0] t, input logic [31:0] a);
    setIns(t, a); step();
  endtask

  task automatic st(input logic [31:0] a);
    setSt(a); step();
  endtask

  task automatic chk(input logic [6:0] t, input logic e, input string n);
    setChk(t, e, n); step();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++; // R1 outputs during reset
    if (chkDone !== 1'b0 || chkFixup !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset outputs: actual=%0b%0b expected=00", chkDone, chkFixup);
    end
    rst = 1'b0;

    chk(7'd5, 1'b1, "R1 empty after reset");

    // R9: fill, then round-robin evictions from entry 0
    for (int i = 0; i < 8; i++) ins(7'(10 + i), 32'h1000 + 32'(i * 64));
    ins(7'd20, 32'h2000);              // evicts entry 0 (tag 10)
    ins(7'd21, 32'h2040);              // evicts entry 1 (tag 11)
    chk(7'd10, 1'b1, "R9 first victim");
    chk(7'd11, 1'b1, "R9 second victim");
    chk(7'd12, 1'b0, "R9 survivor");   // frees entry 2
    ins(7'd22, 32'h2080);              // takes free entry 2, no eviction
    chk(7'd13, 1'b0, "R9 no eviction with free entry");
    chk(7'd22, 1'b0, "R9 new tag");
    chk(7'd20, 1'b0, "R9 replacement 1");
    chk(7'd21, 1'b0, "R9 replacement 2");
    chk(7'd12, 1'b1, "R7 released entry");
    setIns(7'd14, 32'h3000); step();   // tag 14 still live: overwrite
    setChk(7'd3, 1'b1, "R3 absent tag"); step();
    flushReq = 1'b1; step();
    for (int i = 14; i < 18; i++) chk(7'(i), 1'b1, "R11 flushed entry");

    // R2/R3
    ins(7'd3, 32'h100);
    chk(7'd3, 1'b0, "R2 pass");
    chk(7'd4, 1'b1, "R3 never inserted");

    // R4/R5
    ins(7'd5, 32'h208);
    st(32'h20F);
    chk(7'd5, 1'b1, "R4 low bits ignored");
    ins(7'd6, 32'h300);
    st(32'h308);
    chk(7'd6, 1'b0, "R5 other word");

    // R6
    ins(7'd7, 32'h400);
    ins(7'd8, 32'h404);
    ins(7'd9, 32'h500);
    st(32'h403);
    chk(7'd7, 1'b1, "R6 match a");
    chk(7'd8, 1'b1, "R6 match b");
    chk(7'd9, 1'b0, "R6 non-match");

    // R8
    ins(7'd30, 32'h600);
    ins(7'd30, 32'h700);
    st(32'h600);
    chk(7'd30, 1'b0, "R8 old address ignored");
    ins(7'd31, 32'h800);
    ins(7'd31, 32'h900);
    st(32'h900);
    chk(7'd31, 1'b1, "R8 new address kills");

    // R10
    ins(7'd40, 32'hA00);
    setIns(7'd41, 32'hA00); setSt(32'hA04); step();
    chk(7'd40, 1'b1, "R10 older killed");
    chk(7'd41, 1'b0, "R10 insert wins");

    // R12
    ins(7'd50, 32'hB00);
    setChk(7'd50, 1'b0, "R12 check before store"); setSt(32'hB00); step();
    chk(7'd50, 1'b1, "R12 after store");
    setChk(7'd51, 1'b1, "R12 insert not visible"); setIns(7'd51, 32'hB40); step();
    chk(7'd51, 1'b0, "R12 insert visible next cycle");

    // R11
    ins(7'd60, 32'hC00);
    ins(7'd61, 32'hC40);
    flushReq = 1'b1; setIns(7'd62, 32'hC80); step();
    chk(7'd60, 1'b1, "R11 flush a");
    chk(7'd61, 1'b1, "R11 flush b");
    chk(7'd62, 1'b1, "R11 insert dropped");

    repeat (3) step();
    checks++;
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL R2 missing results: actual=%0d expected=0", expQ.size());
    end
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule